// File: doc/BRIEF.md
# Delay-Slot Micro-PC Sequencer

This block keeps the program-counter state of a processor front end that has a branch delay slot and splits some instructions into micro-ops. It holds three fetch addresses: the current one, the next one and the one after that. It also holds a pair of micro-op counters, the current one and the next one. Each clock edge applies at most one command. A load places the state at a given address. An advance moves the address pipeline forward by one instruction. A micro-advance steps the micro-op counters. A micro-end finishes a cracked instruction. Redirect writes replace the next address, the next-next address or the next micro counter.

A combinational flag, `nonSeq`, reports when the state has left plain sequential flow, so that fetch logic knows a branch or a micro-op jump is pending. The check accepts one skipped instruction between the current and next address, which is what a taken branch whose target lies just past the delay slot looks like. The micro counter pair is part of the same check.

A second combinational output, `stateMatch`, compares the whole state with a reference state given on the `ref*` inputs. The instruction size and all widths are parameters. With `HAS_DELAY` at 0 there is no third address stage: `nextNextPc` is then the next address plus one instruction, an advance adds one instruction to the next address, and the flag checks only that the next address is one instruction ahead. With `HAS_UOP` at 0 the micro counters are fixed at 0 and 1.

Top module: `dslot_pc_seq`

## Requirements
- R1: A load of address V (`cmdLoad`=1) makes `curPc`=V, `nextPc`=V+INST_BYTES and `nextNextPc`=V+2*INST_BYTES after the next clock edge.
- R2: A load sets `curUpc` to 0 and `nextUpc` to 1.
- R3: An advance (`cmdAdvance`) moves `nextPc` into `curPc` and `nextNextPc` into `nextPc`, and sets `nextNextPc` to its old value plus INST_BYTES. The micro counters are left unchanged.
- R4: A micro-advance (`cmdMicroAdv`) copies `nextUpc` into `curUpc` and sets `nextUpc` to its old value plus 1. The addresses are left unchanged.
- R5: A micro-end (`cmdMicroEnd`) performs one advance as in R3 and sets `curUpc`=0 and `nextUpc`=1.
- R6: `nonSeq` is 0 exactly when all three of these hold: `nextNextPc` equals `nextPc`+INST_BYTES; `nextPc` equals `curPc`+INST_BYTES or `curPc`+2*INST_BYTES; `nextUpc` equals `curUpc`+1. Otherwise `nonSeq` is 1.
- R7: When several commands are asserted in one cycle, exactly one class takes effect. The order from highest is load, then redirect writes (all asserted write enables apply together), then micro-end, then advance, then micro-advance. Lower commands in that cycle have no effect.
- R8: While `rstN` is 0 at a clock edge, the state is loaded with RESET_VEC by the rules of R1 and R2.
- R9: Address sums wrap modulo 2^ADDR_W, and micro counter sums wrap modulo 2^UPC_W. A wrapped sum counts as sequential for R6.
- R10: `wrNpc`, `wrNnpc` and `wrNupc` replace `nextPc`, `nextNextPc` and `nextUpc` at the next clock edge. A later advance or micro-advance follows the redirected values.
- R11: `stateMatch` is 1 only when `curPc`, `nextPc`, `nextNextPc`, `curUpc` and `nextUpc` all equal `refPc`, `refNpc`, `refNnpc`, `refUpc` and `refNupc` respectively.
- R12: In a cycle with no command asserted, the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; loads RESET_VEC |
| cmdLoad | input | 1 | Load command |
| loadAddr | input | ADDR_W | Address used by a load |
| cmdAdvance | input | 1 | Advance command |
| cmdMicroAdv | input | 1 | Micro-advance command |
| cmdMicroEnd | input | 1 | Micro-end command |
| wrNpc | input | 1 | Redirect write enable for the next address |
| wrNpcVal | input | ADDR_W | New next address |
| wrNnpc | input | 1 | Redirect write enable for the next-next address |
| wrNnpcVal | input | ADDR_W | New next-next address |
| wrNupc | input | 1 | Redirect write enable for the next micro counter |
| wrNupcVal | input | UPC_W | New next micro counter |
| refPc | input | ADDR_W | Reference current address |
| refNpc | input | ADDR_W | Reference next address |
| refNnpc | input | ADDR_W | Reference next-next address |
| refUpc | input | UPC_W | Reference micro counter |
| refNupc | input | UPC_W | Reference next micro counter |
| curPc | output | ADDR_W | Current fetch address |
| nextPc | output | ADDR_W | Next fetch address |
| nextNextPc | output | ADDR_W | Next-next fetch address |
| curUpc | output | UPC_W | Current micro counter |
| nextUpc | output | UPC_W | Next micro counter |
| nonSeq | output | 1 | State departs from sequential flow |
| stateMatch | output | 1 | State equals the reference state |

## Verification
Plain sequences of loads, advances and micro-advances show that the shift and step arithmetic is right and that the flag stays low. Redirects of each field are then followed by advances, to show that the flag rises and later clears as the redirected path moves through the pipeline. A skip of exactly one instruction, set up with two writes in the same cycle, separates the accepted skip from a true jump. Commands asserted together show which class wins, and values near the top of the address and counter ranges expose any wrap that is not handled.

// File: rtl/dslot_pc_pkg.sv
package dslot_pc_pkg;
  // one-hot0 strobes from control to datapath
  typedef struct packed {
    logic load;
    logic redirect;
    logic microEnd;
    logic advance;
    logic microAdv;
  } seq_strobe_t;
endpackage

// File: rtl/dslot_pc_ctrl.sv
module dslot_pc_ctrl
  import dslot_pc_pkg::*;
(
  input  logic        cmdLoad,
  input  logic        cmdAdvance,
  input  logic        cmdMicroAdv,
  input  logic        cmdMicroEnd,
  input  logic        wrNpc,
  input  logic        wrNnpc,
  input  logic        wrNupc,
  output seq_strobe_t strobe
);
  logic anyWrite;
  logic freeAfterRedirect;

  assign anyWrite = wrNpc | wrNnpc | wrNupc;
  assign freeAfterRedirect = !cmdLoad && !anyWrite;

  // fixed priority: load > redirect > micro-end > advance > micro-advance
  always_comb begin
    strobe          = '0;
    strobe.load     = cmdLoad;
    strobe.redirect = !cmdLoad && anyWrite;
    strobe.microEnd = freeAfterRedirect && cmdMicroEnd;
    strobe.advance  = freeAfterRedirect && !cmdMicroEnd && cmdAdvance;
    strobe.microAdv = freeAfterRedirect && !cmdMicroEnd && !cmdAdvance && cmdMicroAdv;
  end
endmodule

// File: rtl/dslot_pc_datapath.sv
module dslot_pc_datapath
  import dslot_pc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4,
  parameter int UPC_W      = 8,
  parameter bit HAS_DELAY  = 1'b1,
  parameter bit HAS_UOP    = 1'b1,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strobe,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              wrNpc,
  input  logic [ADDR_W-1:0] wrNpcVal,
  input  logic              wrNnpc,
  input  logic [ADDR_W-1:0] wrNnpcVal,
  input  logic              wrNupc,
  input  logic [UPC_W-1:0]  wrNupcVal,
  output logic [ADDR_W-1:0] pcQ,
  output logic [ADDR_W-1:0] npcQ,
  output logic [ADDR_W-1:0] nnpcQ,
  output logic [UPC_W-1:0]  upcQ,
  output logic [UPC_W-1:0]  nupcQ,
  output logic              nonSeq
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INST_BYTES);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INST_BYTES);
  localparam logic [UPC_W-1:0]  UONE  = UPC_W'(1);

  logic pipeMove;
  logic addrSeq;
  logic uopSeq;

  assign pipeMove = strobe.advance | strobe.microEnd;

  // current and next address; the next address always takes nnpcQ on a move
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= RESET_VEC;
      npcQ <= RESET_VEC + STEP;
    end else if (strobe.load) begin
      pcQ  <= loadAddr;
      npcQ <= loadAddr + STEP;
    end else if (strobe.redirect) begin
      if (wrNpc) npcQ <= wrNpcVal;
    end else if (pipeMove) begin
      pcQ  <= npcQ;
      npcQ <= nnpcQ;
    end
  end

  generate
    if (HAS_DELAY) begin : gen_delay
      always_ff @(posedge clk) begin
        if (!rstN)                 nnpcQ <= RESET_VEC + STEP2;
        else if (strobe.load)      nnpcQ <= loadAddr + STEP2;
        else if (strobe.redirect) begin
          if (wrNnpc) nnpcQ <= wrNnpcVal;
        end else if (pipeMove)     nnpcQ <= nnpcQ + STEP;
      end
      assign addrSeq = (nnpcQ == npcQ + STEP) &&
                       ((npcQ == pcQ + STEP) || (npcQ == pcQ + STEP2));
    end else begin : gen_nodelay
      assign nnpcQ   = npcQ + STEP;
      assign addrSeq = (npcQ == pcQ + STEP);
    end

    if (HAS_UOP) begin : gen_uop
      always_ff @(posedge clk) begin
        if (!rstN || strobe.load || strobe.microEnd) begin
          upcQ  <= '0;
          nupcQ <= UONE;
        end else if (strobe.redirect) begin
          if (wrNupc) nupcQ <= wrNupcVal;
        end else if (strobe.microAdv) begin
          upcQ  <= nupcQ;
          nupcQ <= nupcQ + UONE;
        end
      end
      assign uopSeq = (nupcQ == upcQ + UONE);
    end else begin : gen_nouop
      assign upcQ   = '0;
      assign nupcQ  = UONE;
      assign uopSeq = 1'b1;
    end
  endgenerate

  assign nonSeq = !(addrSeq && uopSeq);
endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
  import dslot_pc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4,
  parameter int UPC_W      = 8,
  parameter bit HAS_DELAY  = 1'b1,
  parameter bit HAS_UOP    = 1'b1,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdLoad,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              cmdAdvance,
  input  logic              cmdMicroAdv,
  input  logic              cmdMicroEnd,
  input  logic              wrNpc,
  input  logic [ADDR_W-1:0] wrNpcVal,
  input  logic              wrNnpc,
  input  logic [ADDR_W-1:0] wrNnpcVal,
  input  logic              wrNupc,
  input  logic [UPC_W-1:0]  wrNupcVal,
  input  logic [ADDR_W-1:0] refPc,
  input  logic [ADDR_W-1:0] refNpc,
  input  logic [ADDR_W-1:0] refNnpc,
  input  logic [UPC_W-1:0]  refUpc,
  input  logic [UPC_W-1:0]  refNupc,
  output logic [ADDR_W-1:0] curPc,
  output logic [ADDR_W-1:0] nextPc,
  output logic [ADDR_W-1:0] nextNextPc,
  output logic [UPC_W-1:0]  curUpc,
  output logic [UPC_W-1:0]  nextUpc,
  output logic              nonSeq,
  output logic              stateMatch
);
  seq_strobe_t strobe;

  dslot_pc_ctrl u_ctrl (
    .cmdLoad(cmdLoad), .cmdAdvance(cmdAdvance), .cmdMicroAdv(cmdMicroAdv),
    .cmdMicroEnd(cmdMicroEnd), .wrNpc(wrNpc), .wrNnpc(wrNnpc),
    .wrNupc(wrNupc), .strobe(strobe)
  );

  dslot_pc_datapath #(
    .ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES), .UPC_W(UPC_W),
    .HAS_DELAY(HAS_DELAY), .HAS_UOP(HAS_UOP), .RESET_VEC(RESET_VEC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadAddr(loadAddr),
    .wrNpc(wrNpc), .wrNpcVal(wrNpcVal), .wrNnpc(wrNnpc), .wrNnpcVal(wrNnpcVal),
    .wrNupc(wrNupc), .wrNupcVal(wrNupcVal),
    .pcQ(curPc), .npcQ(nextPc), .nnpcQ(nextNextPc),
    .upcQ(curUpc), .nupcQ(nextUpc), .nonSeq(nonSeq)
  );

  // R11 full-state comparison
  assign stateMatch = (curPc == refPc) && (nextPc == refNpc) &&
                      (nextNextPc == refNnpc) && (curUpc == refUpc) &&
                      (nextUpc == refNupc);
endmodule

// File: rtl/dslot_pc_checker.sv
module dslot_pc_checker #(
  parameter int ADDR_W     = 32,
  parameter int INST_BYTES = 4,
  parameter int UPC_W      = 8,
  parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdLoad,
  input logic [ADDR_W-1:0] loadAddr,
  input logic              cmdAdvance,
  input logic              cmdMicroAdv,
  input logic              cmdMicroEnd,
  input logic              wrNpc,
  input logic              wrNnpc,
  input logic              wrNupc,
  input logic [ADDR_W-1:0] curPc,
  input logic [ADDR_W-1:0] nextPc,
  input logic [ADDR_W-1:0] nextNextPc,
  input logic [UPC_W-1:0]  curUpc,
  input logic [UPC_W-1:0]  nextUpc,
  input logic              nonSeq
);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INST_BYTES);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INST_BYTES);
  localparam logic [UPC_W-1:0]  UONE  = UPC_W'(1);

  logic anyWr;
  logic noCmd;
  assign anyWr = wrNpc | wrNnpc | wrNupc;
  assign noCmd = !cmdLoad && !anyWr && !cmdAdvance && !cmdMicroAdv && !cmdMicroEnd;

  assert_load_addr_R1: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad |=> (curPc == $past(loadAddr)) && (nextPc == $past(loadAddr) + STEP) &&
                (nextNextPc == $past(loadAddr) + STEP2));

  assert_load_uop_R2: assert property (@(posedge clk) disable iff (!rstN)
    cmdLoad |=> (curUpc == '0) && (nextUpc == UONE) && !nonSeq);

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdAdvance && !cmdLoad && !anyWr && !cmdMicroEnd) |=>
      (curPc == $past(nextPc)) && (nextPc == $past(nextNextPc)) &&
      (nextNextPc == $past(nextNextPc) + STEP) && $stable(curUpc) && $stable(nextUpc));

  assert_micro_adv_R4: assert property (@(posedge clk) disable iff (!rstN)
    (cmdMicroAdv && !cmdLoad && !anyWr && !cmdMicroEnd && !cmdAdvance) |=>
      (curUpc == $past(nextUpc)) && (nextUpc == $past(nextUpc) + UONE) && $stable(curPc));

  assert_micro_end_R5: assert property (@(posedge clk) disable iff (!rstN)
    (cmdMicroEnd && !cmdLoad && !anyWr) |=>
      (curPc == $past(nextPc)) && (curUpc == '0) && (nextUpc == UONE));

  assert_redirect_prio_R7: assert property (@(posedge clk) disable iff (!rstN)
    (anyWr && !cmdLoad) |=> $stable(curPc) && $stable(curUpc));

  assert_reset_vec_R8: assert property (@(posedge clk)
    !rstN |=> (curPc == RESET_VEC) && (nextPc == RESET_VEC + STEP) && (curUpc == '0));

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rstN)
    noCmd |=> $stable(curPc) && $stable(nextPc) && $stable(nextNextPc) &&
              $stable(curUpc) && $stable(nextUpc));
endmodule

bind dslot_pc_seq dslot_pc_checker #(
  .ADDR_W(ADDR_W), .INST_BYTES(INST_BYTES), .UPC_W(UPC_W), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .loadAddr(loadAddr),
  .cmdAdvance(cmdAdvance), .cmdMicroAdv(cmdMicroAdv), .cmdMicroEnd(cmdMicroEnd),
  .wrNpc(wrNpc), .wrNnpc(wrNnpc), .wrNupc(wrNupc),
  .curPc(curPc), .nextPc(nextPc), .nextNextPc(nextNextPc),
  .curUpc(curUpc), .nextUpc(nextUpc), .nonSeq(nonSeq)
);

// File: tb/tb_dslot_pc_seq.sv
module tb_dslot_pc_seq;
  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdLoad, cmdAdvance, cmdMicroAdv, cmdMicroEnd;
  logic [31:0] loadAddr;
  logic        wrNpc, wrNnpc, wrNupc;
  logic [31:0] wrNpcVal, wrNnpcVal;
  logic [7:0]  wrNupcVal;
  logic [31:0] refPc, refNpc, refNnpc;
  logic [7:0]  refUpc, refNupc;
  logic [31:0] curPc, nextPc, nextNextPc;
  logic [7:0]  curUpc, nextUpc;
  logic        nonSeq, stateMatch;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;  // 50 MHz

  dslot_pc_seq dut (
    .clk(clk), .rstN(rstN), .cmdLoad(cmdLoad), .loadAddr(loadAddr),
    .cmdAdvance(cmdAdvance), .cmdMicroAdv(cmdMicroAdv), .cmdMicroEnd(cmdMicroEnd),
    .wrNpc(wrNpc), .wrNpcVal(wrNpcVal), .wrNnpc(wrNnpc), .wrNnpcVal(wrNnpcVal),
    .wrNupc(wrNupc), .wrNupcVal(wrNupcVal),
    .refPc(refPc), .refNpc(refNpc), .refNnpc(refNnpc), .refUpc(refUpc), .refNupc(refNupc),
    .curPc(curPc), .nextPc(nextPc), .nextNextPc(nextNextPc),
    .curUpc(curUpc), .nextUpc(nextUpc), .nonSeq(nonSeq), .stateMatch(stateMatch)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic chkState(input string tag, input logic [31:0] p, input logic [31:0] n,
                          input logic [31:0] nn, input logic [7:0] u, input logic [7:0] nu);
    chk({tag, " pc"}, curPc, p);
    chk({tag, " npc"}, nextPc, n);
    chk({tag, " nnpc"}, nextNextPc, nn);
    chk({tag, " upc"}, {24'd0, curUpc}, {24'd0, u});
    chk({tag, " nupc"}, {24'd0, nextUpc}, {24'd0, nu});
  endtask

  task automatic clearIn();
    cmdLoad = 0; cmdAdvance = 0; cmdMicroAdv = 0; cmdMicroEnd = 0;
    wrNpc = 0; wrNnpc = 0; wrNupc = 0;
    loadAddr = '0; wrNpcVal = '0; wrNnpcVal = '0; wrNupcVal = '0;
  endtask

  // inputs are set just after a negedge; this applies them for one edge
  task automatic tick();
    @(negedge clk);
    clearIn();
  endtask

  task automatic doLoad(input logic [31:0] a);
    cmdLoad = 1; loadAddr = a; tick();
  endtask

  task automatic testReset();
    rstN = 0; clearIn();
    refPc = '0; refNpc = '0; refNnpc = '0; refUpc = '0; refNupc = '0;
    @(negedge clk); @(negedge clk);
    chkState("R8 reset", 32'h100, 32'h104, 32'h108, 8'd0, 8'd1);
    rstN = 1;
    @(negedge clk);
    chk("R6 reset flag", {31'd0, nonSeq}, 32'd0);
  endtask

  task automatic testLoadAdvance();
    doLoad(32'h2000);
    chkState("R1 R2 load", 32'h2000, 32'h2004, 32'h2008, 8'd0, 8'd1);
    cmdAdvance = 1; tick();
    cmdAdvance = 1; tick();
    chkState("R3 advance", 32'h2008, 32'h200C, 32'h2010, 8'd0, 8'd1);
    chk("R6 seq flag", {31'd0, nonSeq}, 32'd0);
  endtask

  task automatic testMicro();
    cmdMicroAdv = 1; tick();
    cmdMicroAdv = 1; tick();
    chkState("R4 micro-advance", 32'h2008, 32'h200C, 32'h2010, 8'd2, 8'd3);
    cmdMicroEnd = 1; tick();
    chkState("R5 micro-end", 32'h200C, 32'h2010, 32'h2014, 8'd0, 8'd1);
    // load after micro steps resets the counters
    cmdMicroAdv = 1; tick();
    doLoad(32'h500);
    chkState("R2 load clears uop", 32'h500, 32'h504, 32'h508, 8'd0, 8'd1);
  endtask

  task automatic testRedirect();
    doLoad(32'h2000);
    wrNnpc = 1; wrNnpcVal = 32'h3000; tick();
    chkState("R10 nnpc write", 32'h2000, 32'h2004, 32'h3000, 8'd0, 8'd1);
    chk("R6 branch pending", {31'd0, nonSeq}, 32'd1);
    cmdAdvance = 1; tick();
    chkState("R10 follow 1", 32'h2004, 32'h3000, 32'h3004, 8'd0, 8'd1);
    chk("R6 in delay slot", {31'd0, nonSeq}, 32'd1);
    cmdAdvance = 1; tick();
    chkState("R10 follow 2", 32'h3000, 32'h3004, 32'h3008, 8'd0, 8'd1);
    chk("R6 back to seq", {31'd0, nonSeq}, 32'd0);
  endtask

  task automatic testSkipOne();
    doLoad(32'h40);
    wrNpc = 1; wrNpcVal = 32'h48; wrNnpc = 1; wrNnpcVal = 32'h4C; tick();
    chkState("R10 both writes", 32'h40, 32'h48, 32'h4C, 8'd0, 8'd1);
    chk("R6 one skip is seq", {31'd0, nonSeq}, 32'd0);
    wrNpc = 1; wrNpcVal = 32'h4C; tick();
    chk("R6 nnpc not npc+4", {31'd0, nonSeq}, 32'd1);
    doLoad(32'h40);
    wrNpc = 1; wrNpcVal = 32'h4C; wrNnpc = 1; wrNnpcVal = 32'h50; tick();
    chk("R6 two skips", {31'd0, nonSeq}, 32'd1);
    doLoad(32'h40);
    wrNupc = 1; wrNupcVal = 8'd5; tick();
    chk("R6 micro jump", {31'd0, nonSeq}, 32'd1);
    cmdMicroAdv = 1; tick();
    chkState("R10 uop follows", 32'h40, 32'h44, 32'h48, 8'd5, 8'd6);
    chk("R6 micro seq again", {31'd0, nonSeq}, 32'd0);
  endtask

  task automatic testPriority();
    doLoad(32'h1000);
    cmdLoad = 1; loadAddr = 32'h7000; cmdAdvance = 1; wrNpc = 1; wrNpcVal = 32'h9; tick();
    chkState("R7 load wins", 32'h7000, 32'h7004, 32'h7008, 8'd0, 8'd1);
    wrNpc = 1; wrNpcVal = 32'h7010; cmdAdvance = 1; cmdMicroEnd = 1; tick();
    chkState("R7 redirect wins", 32'h7000, 32'h7010, 32'h7008, 8'd0, 8'd1);
    doLoad(32'h7000);
    cmdMicroAdv = 1; tick();
    cmdMicroEnd = 1; cmdAdvance = 1; cmdMicroAdv = 1; tick();
    chkState("R7 micro-end single step", 32'h7004, 32'h7008, 32'h700C, 8'd0, 8'd1);
    cmdAdvance = 1; cmdMicroAdv = 1; tick();
    chkState("R7 advance beats micro", 32'h7008, 32'h700C, 32'h7010, 8'd0, 8'd1);
  endtask

  task automatic testWrap();
    doLoad(32'hFFFF_FFFC);
    chkState("R9 addr wrap", 32'hFFFF_FFFC, 32'h0, 32'h4, 8'd0, 8'd1);
    chk("R9 wrapped seq", {31'd0, nonSeq}, 32'd0);
    wrNupc = 1; wrNupcVal = 8'd255; tick();
    cmdMicroAdv = 1; tick();
    chkState("R9 uop wrap", 32'hFFFF_FFFC, 32'h0, 32'h4, 8'd255, 8'd0);
    chk("R9 uop wrap seq", {31'd0, nonSeq}, 32'd0);
  endtask

  task automatic testMatchIdle();
    doLoad(32'h800);
    refPc = 32'h800; refNpc = 32'h804; refNnpc = 32'h808; refUpc = 8'd0; refNupc = 8'd1;
    #1;
    chk("R11 match", {31'd0, stateMatch}, 32'd1);
    refNupc = 8'd2; #1;
    chk("R11 nupc differs", {31'd0, stateMatch}, 32'd0);
    refNupc = 8'd1; refNnpc = 32'h80C; #1;
    chk("R11 nnpc differs", {31'd0, stateMatch}, 32'd0);
    tick(); tick(); tick();
    chkState("R12 idle", 32'h800, 32'h804, 32'h808, 8'd0, 8'd1);
    cmdAdvance = 1; tick();
    rstN = 0; tick();
    rstN = 1;
    chkState("R8 mid-run reset", 32'h100, 32'h104, 32'h108, 8'd0, 8'd1);
  endtask

  initial begin
    testReset();
    testLoadAdvance();
    testMicro();
    testRedirect();
    testSkipOne();
    testPriority();
    testWrap();
    testMatchIdle();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #(20 * 200000);
    testsFailed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule